// File: doc/BRIEF.md
# Audio Sample Buffer with Event and Interrupt Logic

This block sits between a host bus and a pair of serial audio engines. It holds one transmit queue, which the host fills and the transmit engine drains, and one receive queue, which the receive engine fills and the host drains. Each queue is a parameterised ring of 32-bit words. Around the queues sit three things: level comparisons against programmable thresholds, an inactivity timer for each direction, and a sticky 32-bit event register. The event register can be forced by software, cleared by writing ones and masked, and it drives a single interrupt line.

The serial engines connect only through the push and pop strobes. For debug the host can flush either queue, and it can freeze the hardware side of a queue. Freezing the transmit queue stops engine pops. Freezing the receive queue stops engine pushes. The receive head word is always visible on the read data port, so the host can sample it any number of times without removing it. Only a pop advances the queue.

Top module: `audio_fifo_irq`

## Requirements
- R1: While rst_ni is low and after its release, both levels read 0, the status and masked outputs read 0 and irq_o is 0.
- R2: Each queue returns words in the order they were pushed. Its level rises by one for each accepted push and falls by one for each accepted pop. The read data port shows the oldest stored word.
- R3: A push into a full queue is dropped and the level stays at DEPTH. A pop from an empty queue changes nothing. The attempt sets status bit 5 (tx push while full), bit 6 (tx pop while empty), bit 21 (rx push while full) or bit 22 (rx pop while empty).
- R4: Level flags go into status as follows: bit 1 when tx level < DEPTH, bit 4 when tx level is 0, bit 18 when rx level > 0, bit 19 when rx level equals DEPTH.
- R5: Status bit 0 is set when the tx level is below tx_trig_lvl_i. Status bit 16 is set when the rx level is above rx_trig_lvl_i.
- R6: A clear pulse empties its queue: the level reads 0 on the next cycle and the next word pushed becomes the head.
- R7: With tx_freeze_i high, tx_pop_i leaves the tx level and head word unchanged. With rx_freeze_i high, rx_push_i stores nothing and the rx level is unchanged.
- R8: rx_rdata_o presents the receive head without a pop. Reading it on several cycles gives the same word and leaves the rx level unchanged.
- R9: A status bit is latched at the clock edge that ends the cycle in which its condition holds, and it stays set until cleared by a one in irq_clr_i. A one in irq_set_i sets the bit, and set wins over clear in the same cycle. Bits other than 0,1,4,5,6,8,16,18,19,21,22,24 always read 0.
- R10: irq_masked_o equals status AND irq_mask_i. irq_o is high exactly when irq_masked_o is nonzero.
- R11: An enabled direction timer sets status bit 8 (tx) or bit 24 (rx) N clock edges after the later of its enable and the last push or pop strobe in that direction, where N is its reload value (N>0). With the timer disabled the bit is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_push_i | input | 1 | Host writes a word into the transmit queue |
| tx_wdata_i | input | 32 | Transmit word to store |
| tx_pop_i | input | 1 | Transmit engine takes the head word |
| tx_rdata_o | output | 32 | Transmit head word |
| tx_clear_i | input | 1 | Flush the transmit queue |
| tx_freeze_i | input | 1 | Block engine pops from the transmit queue |
| tx_trig_lvl_i | input | AW | Transmit threshold |
| tx_level_o | output | LW | Transmit fill level |
| tx_wd_en_i | input | 1 | Transmit timer enable |
| tx_wd_reload_i | input | 32 | Transmit timer reload value |
| rx_push_i | input | 1 | Receive engine stores a word |
| rx_wdata_i | input | 32 | Receive word to store |
| rx_pop_i | input | 1 | Host removes the head word |
| rx_rdata_o | output | 32 | Receive head word |
| rx_clear_i | input | 1 | Flush the receive queue |
| rx_freeze_i | input | 1 | Block engine pushes into the receive queue |
| rx_trig_lvl_i | input | AW | Receive threshold |
| rx_level_o | output | LW | Receive fill level |
| rx_wd_en_i | input | 1 | Receive timer enable |
| rx_wd_reload_i | input | 32 | Receive timer reload value |
| irq_set_i | input | 32 | Force status bits |
| irq_clr_i | input | 32 | Clear status bits (write one to clear) |
| irq_mask_i | input | 32 | Interrupt enable mask |
| irq_status_o | output | 32 | Sticky raw status |
| irq_masked_o | output | 32 | Status gated by mask |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can meet in one cycle. A status clear can coincide with a live event condition, and a software set can coincide with a clear of the same bit. The level sweeps provoke the first case on purpose: every status sample is taken just after a clear-all pulse, so the status must equal the conditions that hold at the current level, which the bench computes from the level and threshold. The set and clear collision is driven directly on the receive timer bit, which is otherwise quiet, and the bit must read as set afterwards.

// File: rtl/audio_fifo_pkg.sv
package audio_fifo_pkg;
  localparam int unsigned IRQ_W = 32;

  localparam int unsigned EV_TX_TRIG  = 0;
  localparam int unsigned EV_TX_NFULL = 1;
  localparam int unsigned EV_TX_EMPTY = 4;
  localparam int unsigned EV_TX_OVF   = 5;
  localparam int unsigned EV_TX_UNF   = 6;
  localparam int unsigned EV_TX_WD    = 8;
  localparam int unsigned EV_RX_TRIG  = 16;
  localparam int unsigned EV_RX_NEMPT = 18;
  localparam int unsigned EV_RX_FULL  = 19;
  localparam int unsigned EV_RX_OVF   = 21;
  localparam int unsigned EV_RX_UNF   = 22;
  localparam int unsigned EV_RX_WD    = 24;

  localparam logic [IRQ_W-1:0] EV_VALID =
      (IRQ_W'(1) << EV_TX_TRIG)  | (IRQ_W'(1) << EV_TX_NFULL) |
      (IRQ_W'(1) << EV_TX_EMPTY) | (IRQ_W'(1) << EV_TX_OVF)   |
      (IRQ_W'(1) << EV_TX_UNF)   | (IRQ_W'(1) << EV_TX_WD)    |
      (IRQ_W'(1) << EV_RX_TRIG)  | (IRQ_W'(1) << EV_RX_NEMPT) |
      (IRQ_W'(1) << EV_RX_FULL)  | (IRQ_W'(1) << EV_RX_OVF)   |
      (IRQ_W'(1) << EV_RX_UNF)   | (IRQ_W'(1) << EV_RX_WD);
endpackage

// File: rtl/afifo_store.sv
module afifo_store #(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clear_i,
  input  logic          push_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          pop_i,
  input  logic          freeze_wr_i,
  input  logic          freeze_rd_i,
  output logic [DW-1:0] rdata_o,
  output logic [LW-1:0] level_o,
  output logic          full_o,
  output logic          empty_o
);
  logic [DW-1:0] mem_q [DEPTH];
  logic [AW-1:0] wptr_q, rptr_q;
  logic [LW-1:0] cnt_q;
  logic          push_ok, pop_ok;

  assign full_o  = (cnt_q == LW'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign push_ok = push_i && !full_o && !freeze_wr_i;
  assign pop_ok  = pop_i && !empty_o && !freeze_rd_i;
  assign rdata_o = mem_q[rptr_q];
  assign level_o = cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk_i) begin
    if (push_ok && !clear_i) mem_q[wptr_q] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else if (clear_i) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (push_ok) wptr_q <= nxt(wptr_q);
      if (pop_ok)  rptr_q <= nxt(rptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + LW'(1);
        2'b01:   cnt_q <= cnt_q - LW'(1);
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  // R7
  fifo_rd_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_rd_i && !clear_i) |=> (rptr_q == $past(rptr_q)));
  // R7
  fifo_wr_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (freeze_wr_i && !clear_i) |=> (wptr_q == $past(wptr_q)));
  // R6
  fifo_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (level_o == '0));
  // R3
  fifo_no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && full_o && !pop_i && !clear_i) |=> full_o);
endmodule

// File: rtl/afifo_wdog.sv
module afifo_wdog #(
  parameter int unsigned CW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [CW-1:0] reload_i,
  input  logic          act_i,
  output logic          fire_o
);
  logic [CW-1:0] cnt_q;

  // expiry is the step from one to zero
  assign fire_o = en_i && !act_i && (cnt_q == CW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 cnt_q <= '0;
    else if (!en_i || act_i)     cnt_q <= reload_i;
    else if (cnt_q != '0)        cnt_q <= cnt_q - CW'(1);
  end

  // R11
  wd_reload_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act_i |=> (cnt_q == $past(reload_i)));
endmodule

// File: rtl/afifo_irq.sv
module afifo_irq #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] masked_o,
  output logic         irq_o
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= '0;
    else         st_q <= ((st_q & ~clr_i) | raw_i | set_i) & VALID;
  end

  assign status_o = st_q;
  assign masked_o = st_q & mask_i;
  assign irq_o    = |masked_o;

  // R9
  irq_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(set_i & VALID)) |=> ((st_q & $past(set_i & VALID)) == $past(set_i & VALID)));
  // R9
  irq_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(clr_i & ~set_i & ~raw_i)) |=> ((st_q & $past(clr_i & ~set_i & ~raw_i)) == '0));
endmodule

// File: rtl/audio_fifo_irq.sv
module audio_fifo_irq
  import audio_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned DW    = 32,
  parameter int unsigned WDW   = 32,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tx_push_i,
  input  logic [DW-1:0]    tx_wdata_i,
  input  logic             tx_pop_i,
  output logic [DW-1:0]    tx_rdata_o,
  input  logic             tx_clear_i,
  input  logic             tx_freeze_i,
  input  logic [AW-1:0]    tx_trig_lvl_i,
  output logic [LW-1:0]    tx_level_o,
  input  logic             tx_wd_en_i,
  input  logic [WDW-1:0]   tx_wd_reload_i,
  input  logic             rx_push_i,
  input  logic [DW-1:0]    rx_wdata_i,
  input  logic             rx_pop_i,
  output logic [DW-1:0]    rx_rdata_o,
  input  logic             rx_clear_i,
  input  logic             rx_freeze_i,
  input  logic [AW-1:0]    rx_trig_lvl_i,
  output logic [LW-1:0]    rx_level_o,
  input  logic             rx_wd_en_i,
  input  logic [WDW-1:0]   rx_wd_reload_i,
  input  logic [IRQ_W-1:0] irq_set_i,
  input  logic [IRQ_W-1:0] irq_clr_i,
  input  logic [IRQ_W-1:0] irq_mask_i,
  output logic [IRQ_W-1:0] irq_status_o,
  output logic [IRQ_W-1:0] irq_masked_o,
  output logic             irq_o
);
  logic tx_full, tx_empty, rx_full, rx_empty;
  logic tx_wd_fire, rx_wd_fire;
  logic [IRQ_W-1:0] raw;

  afifo_store #(.DEPTH(DEPTH), .DW(DW)) u_tx_fifo (
    .clk_i, .rst_ni,
    .clear_i(tx_clear_i), .push_i(tx_push_i), .wdata_i(tx_wdata_i),
    .pop_i(tx_pop_i), .freeze_wr_i(1'b0), .freeze_rd_i(tx_freeze_i),
    .rdata_o(tx_rdata_o), .level_o(tx_level_o),
    .full_o(tx_full), .empty_o(tx_empty)
  );

  afifo_store #(.DEPTH(DEPTH), .DW(DW)) u_rx_fifo (
    .clk_i, .rst_ni,
    .clear_i(rx_clear_i), .push_i(rx_push_i), .wdata_i(rx_wdata_i),
    .pop_i(rx_pop_i), .freeze_wr_i(rx_freeze_i), .freeze_rd_i(1'b0),
    .rdata_o(rx_rdata_o), .level_o(rx_level_o),
    .full_o(rx_full), .empty_o(rx_empty)
  );

  afifo_wdog #(.CW(WDW)) u_tx_wd (
    .clk_i, .rst_ni, .en_i(tx_wd_en_i), .reload_i(tx_wd_reload_i),
    .act_i(tx_push_i | tx_pop_i), .fire_o(tx_wd_fire)
  );

  afifo_wdog #(.CW(WDW)) u_rx_wd (
    .clk_i, .rst_ni, .en_i(rx_wd_en_i), .reload_i(rx_wd_reload_i),
    .act_i(rx_push_i | rx_pop_i), .fire_o(rx_wd_fire)
  );

  always_comb begin
    raw = '0;
    raw[EV_TX_TRIG]  = tx_level_o < LW'(tx_trig_lvl_i);
    raw[EV_TX_NFULL] = !tx_full;
    raw[EV_TX_EMPTY] = tx_empty;
    raw[EV_TX_OVF]   = tx_push_i && tx_full;
    raw[EV_TX_UNF]   = tx_pop_i && tx_empty;
    raw[EV_TX_WD]    = tx_wd_fire;
    raw[EV_RX_TRIG]  = rx_level_o > LW'(rx_trig_lvl_i);
    raw[EV_RX_NEMPT] = !rx_empty;
    raw[EV_RX_FULL]  = rx_full;
    raw[EV_RX_OVF]   = rx_push_i && rx_full;
    raw[EV_RX_UNF]   = rx_pop_i && rx_empty;
    raw[EV_RX_WD]    = rx_wd_fire;
  end

  afifo_irq #(.W(IRQ_W), .VALID(EV_VALID)) u_irq (
    .clk_i, .rst_ni, .raw_i(raw), .set_i(irq_set_i), .clr_i(irq_clr_i),
    .mask_i(irq_mask_i), .status_o(irq_status_o), .masked_o(irq_masked_o),
    .irq_o(irq_o)
  );

  // R3
  tx_overflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_push_i && tx_full) |=> irq_status_o[EV_TX_OVF]);
  // R3
  rx_underflow_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_pop_i && rx_empty) |=> irq_status_o[EV_RX_UNF]);
endmodule

// File: tb/audio_fifo_irq_tb.sv
module audio_fifo_irq_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned AW = $clog2(DEPTH);
  localparam int unsigned LW = $clog2(DEPTH + 1);

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic tx_push_i = 0, tx_pop_i = 0, tx_clear_i = 0, tx_freeze_i = 0, tx_wd_en_i = 0;
  logic rx_push_i = 0, rx_pop_i = 0, rx_clear_i = 0, rx_freeze_i = 0, rx_wd_en_i = 0;
  logic [31:0] tx_wdata_i = '0, rx_wdata_i = '0, tx_rdata_o, rx_rdata_o;
  logic [AW-1:0] tx_trig_lvl_i = '0, rx_trig_lvl_i = '0;
  logic [LW-1:0] tx_level_o, rx_level_o;
  logic [31:0] tx_wd_reload_i = 32'd100, rx_wd_reload_i = 32'd100;
  logic [31:0] irq_set_i = '0, irq_clr_i = '0, irq_mask_i = '0;
  logic [31:0] irq_status_o, irq_masked_o;
  logic irq_o;

  int checks = 0;
  int failures = 0;

  always #4 clk_i = ~clk_i;

  audio_fifo_irq #(.DEPTH(DEPTH)) dut_i (.*);

  task automatic tick(input int n = 1);
    repeat (n) @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  task automatic clr_all();
    irq_clr_i = '1; tick(); irq_clr_i = '0;
  endtask

  function automatic logic [31:0] lvl_bits(input int tl, input int tt, input int rl, input int rt);
    logic [31:0] e = '0;
    e[0]  = tl < tt;
    e[1]  = tl < DEPTH;
    e[4]  = tl == 0;
    e[16] = rl > rt;
    e[18] = rl > 0;
    e[19] = rl == DEPTH;
    return e;
  endfunction

  initial begin
    repeat (200000) @(posedge clk_i);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    @(negedge clk_i);
    // R1 during reset
    chk("R1 status in reset", irq_status_o, 32'h0);
    chk("R1 tx level in reset", 32'(tx_level_o), 0);
    chk("R1 rx level in reset", 32'(rx_level_o), 0);
    chk("R1 irq in reset", 32'(irq_o), 0);
    tick(2);
    rst_ni = 1'b1;
    chk("R1 status after release", irq_status_o, 32'h0);
    chk("R1 masked after release", irq_masked_o, 32'h0);

    // R4 R5 transmit level and threshold sweep
    for (int t = 0; t < DEPTH; t++) begin
      tx_trig_lvl_i = AW'(t);
      tx_clear_i = 1; tick(); tx_clear_i = 0;
      for (int l = 0; l <= DEPTH; l++) begin
        clr_all();
        chk($sformatf("R5 R4 tx status l=%0d t=%0d", l, t), irq_status_o, lvl_bits(l, t, 0, 0));
        chk("R2 tx level", 32'(tx_level_o), l);
        if (l < DEPTH) begin
          tx_push_i = 1; tx_wdata_i = 32'(l); tick(); tx_push_i = 0;
        end
      end
    end
    tx_trig_lvl_i = '0;
    tx_clear_i = 1; tick(); tx_clear_i = 0;

    // R4 R5 receive level and threshold sweep
    for (int t = 0; t < DEPTH; t++) begin
      rx_trig_lvl_i = AW'(t);
      rx_clear_i = 1; tick(); rx_clear_i = 0;
      for (int l = 0; l <= DEPTH; l++) begin
        clr_all();
        chk($sformatf("R5 R4 rx status l=%0d t=%0d", l, t), irq_status_o, lvl_bits(0, 0, l, t));
        chk("R2 rx level", 32'(rx_level_o), l);
        if (l < DEPTH) begin
          rx_push_i = 1; rx_wdata_i = 32'(l); tick(); rx_push_i = 0;
        end
      end
    end
    rx_trig_lvl_i = '0;
    rx_clear_i = 1; tick(); rx_clear_i = 0;

    // R2 R3 transmit order and overflow
    clr_all();
    for (int i = 0; i < DEPTH; i++) begin
      tx_push_i = 1; tx_wdata_i = 32'hA500_0000 + 32'(i * 3); tick();
    end
    tx_wdata_i = 32'hDEAD_BEEF; tick(); tx_push_i = 0;
    chk("R3 tx overflow bit5", 32'(irq_status_o[5]), 1);
    chk("R3 tx level held at full", 32'(tx_level_o), DEPTH);
    tick(3);
    chk("R9 tx overflow sticky", 32'(irq_status_o[5]), 1);
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R2 tx order %0d", i), tx_rdata_o, 32'hA500_0000 + 32'(i * 3));
      tx_pop_i = 1; tick(); tx_pop_i = 0;
    end
    chk("R3 tx no underflow yet", 32'(irq_status_o[6]), 0);
    tx_pop_i = 1; tick(); tx_pop_i = 0;
    chk("R3 tx underflow bit6", 32'(irq_status_o[6]), 1);
    chk("R3 tx level still 0", 32'(tx_level_o), 0);

    // R2 R3 R8 receive order, overflow, peek
    clr_all();
    for (int i = 0; i <= DEPTH; i++) begin
      rx_push_i = 1; rx_wdata_i = 32'h5A00_0100 + 32'(i); tick();
    end
    rx_push_i = 0;
    chk("R3 rx overflow bit21", 32'(irq_status_o[21]), 1);
    chk("R8 peek first", rx_rdata_o, 32'h5A00_0100);
    tick(2);
    chk("R8 peek again", rx_rdata_o, 32'h5A00_0100);
    chk("R8 level unchanged by peek", 32'(rx_level_o), DEPTH);
    for (int i = 0; i < DEPTH; i++) begin
      chk($sformatf("R2 rx order %0d", i), rx_rdata_o, 32'h5A00_0100 + 32'(i));
      rx_pop_i = 1; tick(); rx_pop_i = 0;
    end
    rx_pop_i = 1; tick(); rx_pop_i = 0;
    chk("R3 rx underflow bit22", 32'(irq_status_o[22]), 1);

    // R7 freeze
    tx_push_i = 1; tx_wdata_i = 32'h11; tick(); tx_wdata_i = 32'h22; tick(); tx_push_i = 0;
    tx_freeze_i = 1; tx_pop_i = 1; tick(2); tx_pop_i = 0; tx_freeze_i = 0;
    chk("R7 tx frozen level", 32'(tx_level_o), 2);
    chk("R7 tx frozen head", tx_rdata_o, 32'h11);
    tx_pop_i = 1; tick(); tx_pop_i = 0;
    chk("R7 tx unfrozen head", tx_rdata_o, 32'h22);
    rx_freeze_i = 1; rx_push_i = 1; rx_wdata_i = 32'h33; tick(2); rx_push_i = 0; rx_freeze_i = 0;
    chk("R7 rx frozen level", 32'(rx_level_o), 0);

    // R6 clear
    tx_clear_i = 1; tick(); tx_clear_i = 0;
    chk("R6 tx level after clear", 32'(tx_level_o), 0);
    tx_push_i = 1; tx_wdata_i = 32'h77; tick(); tx_push_i = 0;
    chk("R6 tx head after clear", tx_rdata_o, 32'h77);
    rx_push_i = 1; rx_wdata_i = 32'h44; tick(); rx_wdata_i = 32'h45; tick(); rx_push_i = 0;
    rx_clear_i = 1; tick(); rx_clear_i = 0;
    chk("R6 rx level after clear", 32'(rx_level_o), 0);
    rx_push_i = 1; rx_wdata_i = 32'h99; tick(); rx_push_i = 0;
    chk("R6 rx head after clear", rx_rdata_o, 32'h99);
    tx_clear_i = 1; rx_clear_i = 1; tick(); tx_clear_i = 0; rx_clear_i = 0;

    // R9 R10 set, clear, mask
    clr_all();
    irq_set_i = 32'h0000_0108; tick(); irq_set_i = '0;
    chk("R9 set bit8", 32'(irq_status_o[8]), 1);
    chk("R9 undefined bit3 reads 0", 32'(irq_status_o[3]), 0);
    irq_mask_i = '0; tick();
    chk("R10 irq low with mask 0", 32'(irq_o), 0);
    chk("R10 masked zero", irq_masked_o, 0);
    irq_mask_i = 32'h0000_0100; tick();
    chk("R10 masked bit8", irq_masked_o, 32'h0000_0100);
    chk("R10 irq high", 32'(irq_o), 1);
    irq_clr_i = 32'h0000_0100; tick(); irq_clr_i = '0;
    chk("R9 w1c bit8", 32'(irq_status_o[8]), 0);
    chk("R10 irq drops", 32'(irq_o), 0);
    irq_mask_i = '0;
    irq_set_i = 32'h0100_0000; irq_clr_i = 32'h0100_0000; tick();
    irq_set_i = '0; irq_clr_i = '0;
    chk("R9 set wins over clear", 32'(irq_status_o[24]), 1);

    // R11 timers
    tx_wd_reload_i = 32'd2; tick();
    clr_all();
    tick(20);
    chk("R11 disabled tx timer silent", 32'(irq_status_o[8]), 0);
    tx_wd_reload_i = 32'd5; tick();
    clr_all();
    tx_wd_en_i = 1;
    tick(4);
    chk("R11 tx timer before expiry", 32'(irq_status_o[8]), 0);
    tick();
    chk("R11 tx timer expiry", 32'(irq_status_o[8]), 1);
    tx_wd_en_i = 0;
    rx_wd_reload_i = 32'd4; tick();
    clr_all();
    rx_wd_en_i = 1;
    tick(2);
    rx_push_i = 1; rx_wdata_i = 32'h1; tick(); rx_push_i = 0;
    tick(3);
    chk("R11 rx timer reloaded by push", 32'(irq_status_o[24]), 0);
    tick();
    chk("R11 rx timer expiry after reload", 32'(irq_status_o[24]), 1);
    rx_wd_en_i = 0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule